// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block is the register front end of a battery-backed clock. Software does not address each byte directly. It first writes an index through the address port, then reads or writes the byte that index selects through the data port. Indices 0 to 9 select a ten-byte store of time and date values. Indices 10 to 13 select four status registers (A, B, C, D). Index values above 13 are refused.

The block does not advance the time and has no alarm logic. The clock bytes are plain storage, loaded at reset from parameters. Status register A reports a fixed time base and rate selection, and its update-in-progress flag flips on every read. Status register B takes only a narrow set of values. Its periodic-enable bit gates a free-running interval timer, which emits a one-cycle interrupt pulse every `PERIOD` clock cycles. Registers C and D read as zero. Any write that is refused raises a one-cycle error pulse.

Top module: `rtc_regfile`

## Requirements
- R1: An address-port write (`wr_en`=1, `wr_port`=0) with a value of 0x00 to 0x0D sets the index. A larger value leaves the index unchanged and pulses `err` high in the cycle that follows the write.
- R2: For indices 0 to 9 the data port reads and writes the stored byte. At reset the bytes hold: 0 seconds, 2 minutes, 4 hours, 6 weekday (`INIT_WDAY`+1, so Sunday=1), 7 day of month, 8 month (`INIT_MON`+1, 1-based), 9 year. Bytes 1, 3 and 5 reset to 0x00.
- R3: With `YEAR_BCD`=1, byte 9 resets to the two low decimal digits of `INIT_YEAR` in packed BCD (125 gives 0x25). With `YEAR_BCD`=0 it holds `INIT_YEAR` in binary.
- R4: Status A (index 0x0A) resets to 0x26. A data write of 0x26 is accepted. Any other value is refused: `err` pulses and A keeps its value.
- R5: Each data read of status A inverts bit 7 of A and returns the updated value (0xA6 first after reset, then 0x26).
- R6: Status B (index 0x0B) resets to 0x46 (bit 6 periodic enable, bit 2 binary, bit 1 24-hour). A write is accepted only if bits 2 and 1 are set and bits 7, 5, 4 and 0 are clear, so only bit 6 and bit 3 (square-wave enable) may vary. A refused write pulses `err` and leaves B unchanged.
- R7: Data reads of indices 0x0C and 0x0D return 0x00. Data writes to them pulse `err`.
- R8: While B bit 6 is set, `irq` is a one-cycle pulse repeating every `PERIOD` cycles. The first pulse comes `PERIOD` cycles after the write that set the bit, or after reset release. Rewriting B with bit 6 still set does not restart the interval.
- R9: A write clearing B bit 6 stops the timer at once. `irq` stays low from the following cycle until the bit is set again.
- R10: `rdata` is valid with `rd_valid` high in the cycle after `rd_en`. In a cycle where `wr_en` is high, `rd_en` is ignored and no read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 1 | Write target: 0 address port, 1 data port |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Data-port read strobe |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| err | output | 1 | One-cycle pulse after a refused write |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
A corrupted index shows on the next data read, which returns the wrong byte one cycle after `rd_en`. A wrong update-in-progress bit shows on the first read of A, because the flag's parity across successive reads is fixed. A timer counter that restarts, drifts or keeps running while disabled shows on `irq` within one `PERIOD`, as a gap between pulses that differs from `PERIOD` or as a pulse while the enable is clear. An accepted illegal status write shows on the next read of that register.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int PERIOD    = 16,
  parameter int YEAR_BCD  = 1,
  parameter int INIT_SEC  = 30,
  parameter int INIT_MIN  = 45,
  parameter int INIT_HOUR = 13,
  parameter int INIT_WDAY = 2,
  parameter int INIT_MDAY = 17,
  parameter int INIT_MON  = 5,
  parameter int INIT_YEAR = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_port,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic       err,
  output logic       irq
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int NBYTES = 10;
  localparam logic [3:0] IDX_A = 4'd10;
  localparam logic [3:0] IDX_B = 4'd11;
  localparam logic [3:0] IDX_MAX = 4'd13;
  localparam logic [7:0] A_RST = 8'h26;
  localparam logic [7:0] B_RST = 8'h46;
  localparam logic [7:0] B_VAR = 8'h48;
  localparam logic [7:0] B_FIX = 8'h06;
  localparam int YR2 = INIT_YEAR % 100;
  localparam logic [7:0] YEAR_BYTE = (YEAR_BCD != 0) ? 8'((YR2 / 10) * 16 + (YR2 % 10))
                                                     : 8'(INIT_YEAR);

  function automatic logic [7:0] init_byte(input int i);
    case (i)
      0:       return 8'(INIT_SEC);
      2:       return 8'(INIT_MIN);
      4:       return 8'(INIT_HOUR);
      6:       return 8'(INIT_WDAY + 1);
      7:       return 8'(INIT_MDAY);
      8:       return 8'(INIT_MON + 1);
      9:       return YEAR_BYTE;
      default: return 8'h00;
    endcase
  endfunction

  logic [3:0]    idx_q;
  logic [7:0]    mem [NBYTES];
  logic [7:0]    stat_a, stat_b;
  logic [CW-1:0] cnt;

  wire wr_idx  = wr_en && !wr_port;
  wire wr_dat  = wr_en && wr_port;
  wire rd_go   = rd_en && !wr_en;
  wire is_mem  = idx_q < IDX_A;
  wire idx_bad = wdata > {4'd0, IDX_MAX};
  wire a_bad   = wdata != A_RST;
  wire b_bad   = (wdata & ~B_VAR) != B_FIX;
  wire dat_bad = !is_mem && ((idx_q == IDX_A) ? a_bad : (idx_q == IDX_B) ? b_bad : 1'b1);
  wire b_write = wr_dat && idx_q == IDX_B && !b_bad;
  wire pie     = stat_b[6];
  wire pie_nxt = b_write ? wdata[6] : pie;
  wire tick    = cnt == CW'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      stat_a   <= A_RST;
      stat_b   <= B_RST;
      rdata    <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
      for (int i = 0; i < NBYTES; i++) mem[i] <= init_byte(i);
    end else begin
      err      <= (wr_idx && idx_bad) || (wr_dat && dat_bad);
      rd_valid <= rd_go;
      if (wr_idx && !idx_bad) idx_q <= wdata[3:0];
      if (wr_dat && is_mem) mem[idx_q] <= wdata;
      if (wr_dat && idx_q == IDX_A && !a_bad) stat_a <= wdata;
      if (b_write) stat_b <= wdata;
      if (rd_go) begin
        if (is_mem)               rdata <= mem[idx_q];
        else if (idx_q == IDX_A)  rdata <= stat_a ^ 8'h80;
        else if (idx_q == IDX_B)  rdata <= stat_b;
        else                      rdata <= 8'h00;
        if (idx_q == IDX_A) stat_a <= stat_a ^ 8'h80;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= pie && pie_nxt && tick;
      if (!pie || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) idx_q <= IDX_MAX);
  // R1
  bad_idx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx && idx_bad |=> err && idx_q == $past(idx_q));
  // R5
  uip_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && idx_q == IDX_A |=> rd_valid && rdata[7] != $past(stat_a[7]));
  // R6
  b_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_b[2:1] == 2'b11 && (stat_b & 8'hB1) == 8'h00);
  // R7
  cd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && idx_q > IDX_B |=> rdata == 8'h00);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !pie |=> !irq);
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !rd_valid);

  generate
    if (PERIOD > 1) begin : g_pulse
      // R8
      irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
    end
  endgenerate
endmodule

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;
  localparam int PERIOD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_port = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rd_valid, err, irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  int last_irq = 0;
  bit last_valid = 1'b0;
  bit pie_model = 1'b1;
  int irq_cnt = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_regfile #(.PERIOD(PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid), .err(err), .irq(irq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected rd_valid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
    if (rst_n && irq) begin
      irq_cnt++;
      if (!pie_model) check(1'b0, "R9 irq while disabled", 1, 0);
      else if (last_valid) check(cyc - last_irq == PERIOD, "R8 irq interval", cyc - last_irq, PERIOD);
      last_irq = cyc;
      last_valid = 1'b1;
    end
  end

  task automatic wr(input logic port, input logic [7:0] d, input logic exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_port = port; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(err == exp_err, tag, err, exp_err);
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset contents, R2 R3
    rd(8'd30, "R2 reset sec");
    wr(1'b0, 8'd2, 1'b0, "R1 index 2");   rd(8'd45, "R2 reset min");
    wr(1'b0, 8'd1, 1'b0, "R1 index 1");   rd(8'h00, "R2 reset byte1");
    wr(1'b0, 8'd4, 1'b0, "R1 index 4");   rd(8'd13, "R2 reset hour");
    wr(1'b0, 8'd6, 1'b0, "R1 index 6");   rd(8'd3,  "R2 reset weekday");
    wr(1'b0, 8'd7, 1'b0, "R1 index 7");   rd(8'd17, "R2 reset mday");
    wr(1'b0, 8'd8, 1'b0, "R1 index 8");   rd(8'd6,  "R2 reset month");
    wr(1'b0, 8'd9, 1'b0, "R1 index 9");   rd(8'h25, "R3 bcd year");
    // storage write
    wr(1'b1, 8'h99, 1'b0, "R2 write year");  rd(8'h99, "R2 readback year");
    wr(1'b0, 8'd3, 1'b0, "R1 index 3");
    wr(1'b1, 8'h5A, 1'b0, "R2 write byte3"); rd(8'h5A, "R2 readback byte3");
    // bad index keeps 3
    wr(1'b0, 8'h0E, 1'b1, "R1 index 0x0E err");  rd(8'h5A, "R1 index kept");
    wr(1'b0, 8'hFF, 1'b1, "R1 index 0xFF err");  rd(8'h5A, "R1 index kept 2");
    // status A
    wr(1'b0, 8'd10, 1'b0, "R1 index A");
    rd(8'hA6, "R5 first A read"); rd(8'h26, "R5 second A read"); rd(8'hA6, "R5 third A read");
    wr(1'b1, 8'h27, 1'b1, "R4 bad A write err"); rd(8'h26, "R4 A unchanged");
    wr(1'b1, 8'h26, 1'b0, "R4 good A write");    rd(8'hA6, "R4 A after write");
    // read ignored during write, R10
    @(negedge clk); wr_en = 1'b1; wr_port = 1'b0; wdata = 8'd11; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check(rd_valid == 1'b0, "R10 read ignored with write", rd_valid, 0);
    // status B
    rd(8'h46, "R6 B reset");
    wr(1'b1, 8'h4E, 1'b0, "R6 sqwe write");   rd(8'h4E, "R6 B readback");
    wr(1'b1, 8'h42, 1'b1, "R6 binary clear err"); rd(8'h4E, "R6 B unchanged");
    wr(1'b1, 8'hCE, 1'b1, "R6 bit7 err");      rd(8'h4E, "R6 B unchanged 2");
    // C and D
    wr(1'b0, 8'd12, 1'b0, "R1 index C"); rd(8'h00, "R7 C read");
    wr(1'b1, 8'h00, 1'b1, "R7 C write err");
    wr(1'b0, 8'd13, 1'b0, "R1 index D"); rd(8'h00, "R7 D read");
    wr(1'b1, 8'h12, 1'b1, "R7 D write err");
    // timer: rewrite while running, then disable, then enable
    wr(1'b0, 8'd11, 1'b0, "R1 index B");
    repeat (PERIOD + 5) @(negedge clk);
    wr(1'b1, 8'h46, 1'b0, "R8 rewrite while running");
    repeat (2 * PERIOD) @(negedge clk);
    begin
      automatic int c0 = irq_cnt;
      pie_model = 1'b0; last_valid = 1'b0;
      wr(1'b1, 8'h06, 1'b0, "R9 disable write");
      repeat (3 * PERIOD) @(negedge clk);
      check(irq_cnt == c0, "R9 no irq while disabled", irq_cnt, c0);
    end
    wr(1'b1, 8'h4E, 1'b0, "R8 enable write");
    pie_model = 1'b1; last_irq = cyc; last_valid = 1'b1;
    begin
      automatic int c1 = irq_cnt;
      repeat (2 * PERIOD + 2) @(negedge clk);
      check(irq_cnt - c1 == 2, "R8 pulses after enable", irq_cnt - c1, 2);
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule